// File: doc/BRIEF.md
# Block Transfer Address Sequencer

A move-only processor runs each instruction as two steps: it reads a word from a source address and then writes that word to a destination address. This sequencer turns one such instruction into a run of moves. Software first writes a control word and a repeat count. The next instruction whose two addresses are fetched then runs in block mode. After each completed write the sequencer steps the source and destination address registers and the repeat counter. It also tells the main cycle controller what comes next: another read-and-write pair, or only another write.

The control word holds several settings. A start bit arms the sequencer. A direction bit makes the counter count up or down. Two bit pairs pick increment, decrement or hold for each address. A fill bit reads the source once and then writes the same data again and again. A run ends with the write that completes while the counter reads zero. At that point block mode and the start bit both clear themselves.

Top module: `blk_seq`

## Requirements
- R1: After reset both address registers and the counter are zero, block mode is off, and `rept` and `use_first_src` are low.
- R2: A control write (`cfg_we`=1, `cfg_sel`=0) with bit 0 set arms the block. The next `dst_load` while armed enters block mode. Without arming, `wr_done` leaves the addresses and outputs unchanged.
- R3: `rept` is high exactly while block mode is on and the counter is nonzero. A count of zero at entry gives exactly one transfer.
- R4: Control bit 1 selects the counter direction: 0 counts down and 1 counts up, wrapping at 2^CNT_W. The counter changes only on a `wr_done` in block mode. The number of transfers is count+1 counting down, and 2^CNT_W−count+1 counting up from a nonzero count.
- R5: On each `wr_done` in block mode, bit 2 alone increments the source address and bit 3 alone decrements it. If bits 2 and 3 are equal, the source address holds.
- R6: Bits 4 and 5 act on the destination address in the same way: bit 4 alone increments, bit 5 alone decrements, and equal values hold.
- R7: Control bit 6 selects fill mode. `use_first_src` equals `rept` in fill mode and is low otherwise. In fill mode the source address holds whatever bits 2 and 3 say.
- R8: Address stepping wraps modulo 2^ADDR_W.
- R9: The write that completes with the counter at zero ends block mode and clears the start bit. A later `dst_load` with no new control write stays outside block mode.
- R10: `src_load` or `dst_load` copies `addr_in` into that address register. A load takes priority over stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the control word, 1 selects the repeat count |
| cfg_wdata | input | ADDR_W | Write data |
| addr_in | input | ADDR_W | Fetched operand address |
| src_load | input | 1 | Load the source address register |
| dst_load | input | 1 | Load the destination address register (instruction fetch complete) |
| wr_done | input | 1 | A destination write completed this cycle |
| src_addr | output | ADDR_W | Source address register |
| dst_addr | output | ADDR_W | Destination address register |
| rept | output | 1 | Repeat the transfer after this write |
| use_first_src | output | 1 | Repeat only the write (fill) |

## Verification
The bench builds the block with ADDR_W=16 and CNT_W=8. With these widths, address wrap at both ends of the space can be reached in one step. The counter's up-direction wrap also becomes short: a count of 0xFE gives three transfers. A behavioural model predicts the addresses and both outputs on every cycle. Each block's transfer count and final addresses are also checked against closed-form values.

// File: rtl/blk_seq.sv
module blk_seq #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              src_load,
  input  logic              dst_load,
  input  logic              wr_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              rept,
  output logic              use_first_src
);

  localparam int CTL_W = 7;

  logic [CTL_W-1:0] ctl;
  logic [CNT_W-1:0] cnt;
  logic             active;

  wire armed  = ctl[0];
  wire cnt_up = ctl[1];
  wire fill   = ctl[6];
  wire ctl_wr = cfg_we & ~cfg_sel;
  wire cnt_wr = cfg_we & cfg_sel;
  wire step   = active & wr_done;
  wire last   = (cnt == '0);

  function automatic logic [ADDR_W-1:0] nudge(input logic [ADDR_W-1:0] a,
                                              input logic inc, input logic dec);
    if (inc & ~dec)      return a + 1'b1;
    else if (dec & ~inc) return a - 1'b1;
    else                 return a;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      cnt      <= '0;
      active   <= 1'b0;
      src_addr <= '0;
      dst_addr <= '0;
    end else begin
      if (ctl_wr)           ctl    <= cfg_wdata[CTL_W-1:0];
      else if (step & last) ctl[0] <= 1'b0;

      if (step & last)                       active <= 1'b0;
      else if (dst_load & armed & ~active)   active <= 1'b1;

      if (cnt_wr)             cnt <= cfg_wdata[CNT_W-1:0];
      else if (step & ~last)  cnt <= cnt_up ? cnt + 1'b1 : cnt - 1'b1;

      if (src_load)           src_addr <= addr_in;
      else if (step & ~fill)  src_addr <= nudge(src_addr, ctl[2], ctl[3]);

      if (dst_load)           dst_addr <= addr_in;
      else if (step)          dst_addr <= nudge(dst_addr, ctl[4], ctl[5]);
    end
  end

  assign rept          = active & ~last;
  assign use_first_src = rept & fill;

  a_r7_fill_implies_rept: assert property (@(posedge clk) disable iff (rst)
    use_first_src |-> rept);

  a_r9_end_clears_block: assert property (@(posedge clk) disable iff (rst)
    (active && wr_done && cnt == '0 && !ctl_wr) |=> (!active && !ctl[0] && !rept));

  a_r4_cnt_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!active && !cnt_wr) |=> $stable(cnt));

  a_r5_src_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!src_load && !(active && wr_done)) |=> $stable(src_addr));

  a_r6_dst_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!dst_load && !(active && wr_done)) |=> $stable(dst_addr));

  a_r7_fill_src_hold: assert property (@(posedge clk) disable iff (rst)
    (active && fill && !src_load && !ctl_wr) |=> $stable(src_addr));

endmodule

// File: tb/sim_blk_seq.sv
module sim_blk_seq;
  localparam int AW = 16;
  localparam int CW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_sel = 0, src_load = 0, dst_load = 0, wr_done = 0;
  logic [AW-1:0] cfg_wdata = '0, addr_in = '0;
  logic [AW-1:0] src_addr, dst_addr;
  logic rept, use_first_src;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  blk_seq #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .addr_in(addr_in), .src_load(src_load), .dst_load(dst_load), .wr_done(wr_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .rept(rept), .use_first_src(use_first_src));

  // behavioural reference
  logic [6:0]    m_ctl;
  logic [CW-1:0] m_cnt;
  logic          m_act;
  logic [AW-1:0] m_src, m_dst;

  function automatic logic [AW-1:0] mv(logic [AW-1:0] a, logic i, logic d);
    int delta;
    delta = (i ? 1 : 0) - (d ? 1 : 0);
    return a + AW'(delta);
  endfunction

  always @(posedge clk) begin
    logic [6:0] c; logic [CW-1:0] n; logic a; logic [AW-1:0] s, d; logic fin;
    if (rst) begin
      m_ctl = '0; m_cnt = '0; m_act = 0; m_src = '0; m_dst = '0;
    end else begin
      c = m_ctl; n = m_cnt; a = m_act; s = m_src; d = m_dst;
      fin = m_act && wr_done && (m_cnt == 0);
      if (m_act && wr_done) begin
        if (!fin) n = m_ctl[1] ? m_cnt + 1 : m_cnt - 1;
        if (!m_ctl[6]) s = mv(m_src, m_ctl[2], m_ctl[3]);
        d = mv(m_dst, m_ctl[4], m_ctl[5]);
      end
      if (fin) begin a = 0; c[0] = 0; end
      else if (dst_load && m_ctl[0] && !m_act) a = 1;
      if (cfg_we && !cfg_sel) c = cfg_wdata[6:0];
      if (cfg_we && cfg_sel)  n = cfg_wdata[CW-1:0];
      if (src_load) s = addr_in;
      if (dst_load) d = addr_in;
      m_ctl = c; m_cnt = n; m_act = a; m_src = s; m_dst = d;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    logic er;
    er = m_act && (m_cnt != 0);
    chk("R3 rept per cycle", rept, er);
    chk("R7 use_first_src per cycle", use_first_src, er && m_ctl[6]);
    chk("R5 src per cycle", src_addr, m_src);
    chk("R6 dst per cycle", dst_addr, m_dst);
  end

  task automatic cfg(logic sel, logic [AW-1:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load(logic [AW-1:0] s, logic [AW-1:0] d);
    @(negedge clk); src_load = 1; addr_in = s;
    @(negedge clk); src_load = 0; dst_load = 1; addr_in = d;
    @(negedge clk); dst_load = 0;
  endtask

  task automatic run(output int n, output bit saw_ufs);
    bit r;
    n = 0; saw_ufs = 0;
    do begin
      if (n > 0) @(negedge clk);
      wr_done = 1; r = rept;
      if (use_first_src) saw_ufs = 1;
      n++;
    end while (r && n < 600);
    @(negedge clk); wr_done = 0;
  endtask

  task automatic blk(string tag, logic [6:0] c, int count, logic [AW-1:0] s, logic [AW-1:0] d,
                     int exp_n, logic [AW-1:0] es, logic [AW-1:0] ed, bit exp_ufs);
    int n; bit u;
    cfg(1, AW'(count));
    cfg(0, AW'(c));
    load(s, d);
    run(n, u);
    @(negedge clk);
    chk({tag, " R4 transfer count"}, n, exp_n);
    chk({tag, " R5 final src"}, src_addr, es);
    chk({tag, " R6 final dst"}, dst_addr, ed);
    chk({tag, " R7 fill signal seen"}, u, exp_ufs);
    chk({tag, " R9 block over"}, rept, 0);
  endtask

  initial begin
    int n; bit u;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 src reset", src_addr, 0);
    chk("R1 dst reset", dst_addr, 0);
    chk("R1 rept reset", rept, 0);
    chk("R1 ufs reset", use_first_src, 0);

    // R2: unarmed
    cfg(1, 5); cfg(0, 7'b0010100);
    load(16'h1234, 16'h5678);
    chk("R10 src load", src_addr, 16'h1234);
    chk("R10 dst load", dst_addr, 16'h5678);
    chk("R2 unarmed no rept", rept, 0);
    @(negedge clk); wr_done = 1; repeat (3) @(negedge clk); wr_done = 0;
    @(negedge clk);
    chk("R2 unarmed src", src_addr, 16'h1234);
    chk("R2 unarmed dst", dst_addr, 16'h5678);

    // R2 armed entry, down count, increment both
    cfg(1, 3); cfg(0, 7'b0010101);
    load(16'h0100, 16'h0200);
    chk("R2 armed rept", rept, 1);
    run(n, u); @(negedge clk);
    chk("R4 down count transfers", n, 4);
    chk("R5 src inc", src_addr, 16'h0104);
    chk("R6 dst inc", dst_addr, 16'h0204);

    blk("up", 7'b0101011, 8'hFE, 16'h0300, 16'h0400, 3, 16'h02FD, 16'h03FD, 0);
    blk("zero R3", 7'b0010101, 0, 16'h0010, 16'h0020, 1, 16'h0011, 16'h0021, 0);
    blk("fill", 7'b1010101, 2, 16'h0500, 16'h0600, 3, 16'h0500, 16'h0603, 1);
    blk("hold", 7'b0111101, 2, 16'h0700, 16'h0800, 3, 16'h0700, 16'h0800, 0);
    blk("wrap R8", 7'b0100101, 1, 16'hFFFF, 16'h0000, 2, 16'h0001, 16'hFFFE, 0);
    blk("dec", 7'b0101001, 1, 16'h0900, 16'h0A00, 2, 16'h08FE, 16'h09FE, 0);

    // R9: no rearm
    cfg(1, 4);
    load(16'h0B00, 16'h0C00);
    chk("R9 no rearm rept", rept, 0);
    @(negedge clk); wr_done = 1; @(negedge clk); wr_done = 0; @(negedge clk);
    chk("R9 no rearm dst", dst_addr, 16'h0C00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule